// File: doc/BRIEF.md
# Bus-Matching Width Converter with Endian Select

This block joins an 18-bit narrow port to a 36-bit FIFO word path. It has two independent halves. The receive half takes narrow transfers and assembles them into full 36-bit words, which it offers to a FIFO write interface. The transmit half takes 36-bit words from a FIFO read interface and hands them out again in pieces on a narrow output. Every interface uses a valid/ready handshake. A transfer happens on a rising clock edge when valid and ready are both high.

The narrow side runs either as an 18-bit bus, where two pieces make a word, or as a 9-bit bus on the low bits, where four pieces make a word. The order of the pieces is also selectable. With the MSB-first order, the most significant piece crosses first. With the LSB-first order, the least significant piece crosses first. Both selects are captured while the synchronous reset is high and then held, so one configuration applies to both halves until the next reset. Because the two halves use the same captured order, a word that is packed and then unpacked leaves the narrow output in the order it arrived.

Top module: `bus_match_conv`

## Requirements
- R1: 18-bit mode, MSB-first order (cfg_byte_mode=0, cfg_lsb_first=0): the first accepted rx piece lands in fw_data[35:18] and the second in fw_data[17:0].
- R2: 18-bit mode, LSB-first order (cfg_byte_mode=0, cfg_lsb_first=1): the first accepted rx piece lands in fw_data[17:0] and the second in fw_data[35:18].
- R3: 9-bit mode (cfg_byte_mode=1): four rx pieces make one word, and only rx_data[8:0] is used. With MSB-first order, pieces 0 to 3 fill [35:27], [26:18], [17:9] and [8:0]. With LSB-first order, the fill runs from [8:0] upward. rx_data[17:9] has no effect.
- R4: fw_valid rises only in the cycle after the last piece of a word is accepted. While fw_valid is high and fw_ready is low, fw_data holds steady and rx_ready stays low.
- R5: 18-bit mode unpacking: tx sends fr_data[35:18] first with MSB-first order, and fr_data[17:0] first with LSB-first order.
- R6: 9-bit mode unpacking: tx sends four 9-bit pieces in the order given by R3, and tx_data[17:9] is zero.
- R7: fr_ready is high only when no piece of a held word remains to be sent, or when the last piece is being taken in that same cycle. While tx_valid is high and tx_ready is low, tx_data holds steady.
- R8: cfg_byte_mode and cfg_lsb_first are captured while rst is high. Changing them while rst is low has no effect on packing or unpacking.
- R9: While rst is high, fw_valid and tx_valid read 0. A partly assembled word and a partly sent word are both discarded, so the first word after reset uses only pieces that arrive after reset.
- R10: If fw is connected straight to fr, the sequence of narrow pieces that enters on rx leaves on tx unchanged, in all four size and order combinations. In 9-bit mode the output carries the low nine bits of each input, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures the selects |
| cfg_byte_mode | input | 1 | 1 selects 9-bit pieces, 0 selects 18-bit pieces |
| cfg_lsb_first | input | 1 | 1 selects least significant piece first, 0 most significant first |
| rx_valid | input | 1 | Narrow input piece valid |
| rx_ready | output | 1 | Narrow input can accept a piece |
| rx_data | input | 18 | Narrow input piece |
| fw_valid | output | 1 | Assembled word ready for the FIFO |
| fw_ready | input | 1 | FIFO accepts the word |
| fw_data | output | 36 | Assembled word |
| fr_valid | input | 1 | FIFO has a word to read |
| fr_ready | output | 1 | Converter takes the FIFO word |
| fr_data | input | 36 | Word read from the FIFO |
| tx_valid | output | 1 | Narrow output piece valid |
| tx_ready | input | 1 | Consumer takes the narrow piece |
| tx_data | output | 18 | Narrow output piece |

## Verification
Both halves are run in all four size and order combinations, using data patterns that differ in every piece. The piece-order checks therefore separate a swapped order from a correct one, and in 9-bit mode the upper rx bits are driven non-zero so that any leak into the word shows up. Back-pressure patterns test each half on its own: a stalled write interface shows that words and pieces hold still, and a second word waiting on fr shows that no pop happens in the middle of a word while a back-to-back pop still happens on the last piece. A loopback stream over several words checks that the unpacking order mirrors the packing order. Reset is also applied after a stray partial piece and after a partly sent word, which shows that no stale piece count survives reset.

// File: rtl/bmc_pkg.sv
`timescale 1ns/1ps
package bmc_pkg;

   // Width of each narrow piece
   typedef enum logic {
      BUS_WORD = 1'b0,
      BUS_BYTE = 1'b1
   } bus_size_e;

   // Which end of the wide word crosses the narrow bus first
   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } order_e;

   typedef struct packed {
      bus_size_e size;
      order_e    order;
   } bmc_cfg_t;

endpackage

// File: rtl/bmc_cfg.sv
`timescale 1ns/1ps
module bmc_cfg
   import bmc_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     size_in,
   input  logic     order_in,
   output bmc_cfg_t cfg_q
);

   // The selects are taken only while reset is high
   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q.size  <= bus_size_e'(size_in);
         cfg_q.order <= order_e'(order_in);
      end
   end

   // R8: the captured configuration never moves outside reset
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(cfg_q));

endmodule

// File: rtl/bmc_order.sv
`timescale 1ns/1ps
module bmc_order
   import bmc_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int WPIECES = 2,
   parameter int CW      = 2
)(
   input  bmc_cfg_t        cfg,
   input  logic [CW-1:0]   cnt,
   output logic [CW-1:0]   slot,
   output logic [CW-1:0]   last_cnt,
   output logic            is_last
);

   // Number of pieces per word, minus one, for the captured size
   assign last_cnt = (cfg.size == BUS_BYTE) ? CW'(LANES - 1) : CW'(WPIECES - 1);
   assign is_last  = (cnt == last_cnt);

   // Map the piece's arrival index to its position in the wide word
   assign slot = (cfg.order == ORDER_LSB_FIRST) ? cnt : (last_cnt - cnt);

endmodule

// File: rtl/bmc_pack.sv
`timescale 1ns/1ps
module bmc_pack
   import bmc_pkg::*;
#(
   parameter int WIDE_W   = 36,
   parameter int NARROW_W = 18,
   parameter int BYTE_W   = 9,
   parameter int LANES    = 4,
   parameter int WPIECES  = 2,
   parameter int RATIO    = 2,
   parameter int CW       = 2
)(
   input  logic                clk,
   input  logic                rst,
   input  bmc_cfg_t            cfg,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [NARROW_W-1:0] in_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [WIDE_W-1:0]   out_data
);

   logic [CW-1:0]     cnt;
   logic [CW-1:0]     slot;
   logic [CW-1:0]     last_cnt;
   logic              is_last;
   logic              full;
   logic              take;
   logic [WIDE_W-1:0] acc;

   bmc_order #(.LANES(LANES), .WPIECES(WPIECES), .CW(CW)) u_order (
      .cfg      (cfg),
      .cnt      (cnt),
      .slot     (slot),
      .last_cnt (last_cnt),
      .is_last  (is_last)
   );

   // A new piece may enter while the finished word leaves in the same cycle
   assign in_ready  = !full || out_ready;
   assign take      = in_valid && in_ready;
   assign out_valid = full;
   assign out_data  = acc;

   // One register per 9-bit lane; a lane picks its source from the mode
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      localparam int WSLOT = b / RATIO;
      localparam int SUB   = b % RATIO;
      logic              hit;
      logic [BYTE_W-1:0] src;
      logic [BYTE_W-1:0] q;

      always_comb begin
         if (cfg.size == BUS_BYTE) begin
            hit = (slot == CW'(b));
            src = in_data[BYTE_W-1:0];
         end else begin
            hit = (slot == CW'(WSLOT));
            src = in_data[SUB*BYTE_W +: BYTE_W];
         end
      end

      always_ff @(posedge clk) begin
         if (take && hit) q <= src;
      end

      assign acc[b*BYTE_W +: BYTE_W] = q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         full <= 1'b0;
      end else begin
         if (full && out_ready) full <= 1'b0;
         if (take) begin
            if (is_last) begin
               cnt  <= '0;
               full <= 1'b1;
            end else begin
               cnt  <= cnt + 1'b1;
            end
         end
      end
   end

   // R4: a waiting word stays put until the FIFO takes it
   a_r4_hold_word: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R4: a word appears only right after a narrow piece was accepted
   a_r4_write_after_piece: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(in_valid && in_ready));

   // R3: piece count never passes the mode's piece count
   a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
      cnt <= last_cnt);

endmodule

// File: rtl/bmc_unpack.sv
`timescale 1ns/1ps
module bmc_unpack
   import bmc_pkg::*;
#(
   parameter int WIDE_W   = 36,
   parameter int NARROW_W = 18,
   parameter int BYTE_W   = 9,
   parameter int LANES    = 4,
   parameter int WPIECES  = 2,
   parameter int CW       = 2
)(
   input  logic                clk,
   input  logic                rst,
   input  bmc_cfg_t            cfg,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [WIDE_W-1:0]   in_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [NARROW_W-1:0] out_data
);

   logic [CW-1:0]       cnt;
   logic [CW-1:0]       slot;
   logic [CW-1:0]       last_cnt;
   logic                is_last;
   logic                have;
   logic                send;
   logic                pop;
   logic [WIDE_W-1:0]   hold;
   logic [BYTE_W-1:0]   sel_b;
   logic [NARROW_W-1:0] sel_w;

   bmc_order #(.LANES(LANES), .WPIECES(WPIECES), .CW(CW)) u_order (
      .cfg      (cfg),
      .cnt      (cnt),
      .slot     (slot),
      .last_cnt (last_cnt),
      .is_last  (is_last)
   );

   // Pull a word only when the next piece to send is a first piece
   assign in_ready  = !have || (out_ready && is_last);
   assign pop       = in_valid && in_ready;
   assign send      = have && out_ready;
   assign out_valid = have;

   always_comb begin
      sel_b = '0;
      sel_w = '0;
      for (int i = 0; i < LANES; i++) begin
         if (slot == CW'(i)) sel_b = hold[i*BYTE_W +: BYTE_W];
      end
      for (int i = 0; i < WPIECES; i++) begin
         if (slot == CW'(i)) sel_w = hold[i*NARROW_W +: NARROW_W];
      end
   end

   assign out_data = (cfg.size == BUS_BYTE)
                     ? {{(NARROW_W-BYTE_W){1'b0}}, sel_b}
                     : sel_w;

   always_ff @(posedge clk) begin
      if (pop) hold <= in_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         have <= 1'b0;
      end else begin
         if (send) begin
            if (is_last) begin
               cnt  <= '0;
               have <= 1'b0;
            end else begin
               cnt  <= cnt + 1'b1;
            end
         end
         if (pop) have <= 1'b1;
      end
   end

   // R7: a stalled piece does not change
   a_r7_stall_stable: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R7: no FIFO pop while a word still has unsent pieces beyond this one
   a_r7_no_midword_pop: assert property (@(posedge clk) disable iff (rst)
      have && !is_last |-> !in_ready);

   // R6: piece count stays inside the mode's range
   a_r6_cnt_range: assert property (@(posedge clk) disable iff (rst)
      cnt <= last_cnt);

endmodule

// File: rtl/bus_match_conv.sv
`timescale 1ns/1ps
module bus_match_conv
   import bmc_pkg::*;
#(
   parameter int WIDE_W   = 36,
   parameter int NARROW_W = 18,
   parameter int BYTE_W   = 9
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_byte_mode,
   input  logic                cfg_lsb_first,
   input  logic                rx_valid,
   output logic                rx_ready,
   input  logic [NARROW_W-1:0] rx_data,
   output logic                fw_valid,
   input  logic                fw_ready,
   output logic [WIDE_W-1:0]   fw_data,
   input  logic                fr_valid,
   output logic                fr_ready,
   input  logic [WIDE_W-1:0]   fr_data,
   output logic                tx_valid,
   input  logic                tx_ready,
   output logic [NARROW_W-1:0] tx_data
);

   localparam int WPIECES = WIDE_W / NARROW_W;
   localparam int RATIO   = NARROW_W / BYTE_W;
   localparam int LANES   = WIDE_W / BYTE_W;
   localparam int CW      = (LANES > 1) ? $clog2(LANES) : 1;

   // Elaboration-time parameter checks
   if (WIDE_W % NARROW_W != 0) begin : g_bad_wide
      $error("WIDE_W must be a multiple of NARROW_W");
   end
   if (NARROW_W != RATIO * BYTE_W) begin : g_bad_byte
      $error("NARROW_W must be a multiple of BYTE_W");
   end
   if (WPIECES < 2) begin : g_bad_pieces
      $error("WIDE_W must hold at least two narrow pieces");
   end

   bmc_cfg_t cfg;

   bmc_cfg u_cfg (
      .clk      (clk),
      .rst      (rst),
      .size_in  (cfg_byte_mode),
      .order_in (cfg_lsb_first),
      .cfg_q    (cfg)
   );

   bmc_pack #(
      .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W),
      .LANES(LANES), .WPIECES(WPIECES), .RATIO(RATIO), .CW(CW)
   ) u_pack (
      .clk       (clk),
      .rst       (rst),
      .cfg       (cfg),
      .in_valid  (rx_valid),
      .in_ready  (rx_ready),
      .in_data   (rx_data),
      .out_valid (fw_valid),
      .out_ready (fw_ready),
      .out_data  (fw_data)
   );

   bmc_unpack #(
      .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W),
      .LANES(LANES), .WPIECES(WPIECES), .CW(CW)
   ) u_unpack (
      .clk       (clk),
      .rst       (rst),
      .cfg       (cfg),
      .in_valid  (fr_valid),
      .in_ready  (fr_ready),
      .in_data   (fr_data),
      .out_valid (tx_valid),
      .out_ready (tx_ready),
      .out_data  (tx_data)
   );

endmodule

// File: tb/bus_match_conv_test.sv
`timescale 1ns/1ps
module bus_match_conv_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_byte = 1'b0;
   logic        cfg_lsb = 1'b0;
   logic        rx_valid = 1'b0;
   logic [17:0] rx_data = '0;
   logic        rx_ready;
   logic        fw_valid;
   logic [35:0] fw_data;
   logic        fr_ready;
   logic        tx_valid;
   logic [17:0] tx_data;
   logic        tx_ready = 1'b0;

   logic        loop = 1'b0;
   logic        drv_fw_ready = 1'b0;
   logic        drv_fr_valid = 1'b0;
   logic [35:0] drv_fr_data = '0;
   logic        fw_ready_w;
   logic        fr_valid_w;
   logic [35:0] fr_data_w;

   assign fw_ready_w = loop ? fr_ready : drv_fw_ready;
   assign fr_valid_w = loop ? fw_valid : drv_fr_valid;
   assign fr_data_w  = loop ? fw_data  : drv_fr_data;

   int n_tests = 0;
   int n_fail  = 0;
   logic [17:0] pcs [4];
   logic [17:0] cap [$];
   logic [17:0] sent [$];

   always #5 clk = ~clk;

   bus_match_conv uut (
      .clk           (clk),
      .rst           (rst),
      .cfg_byte_mode (cfg_byte),
      .cfg_lsb_first (cfg_lsb),
      .rx_valid      (rx_valid),
      .rx_ready      (rx_ready),
      .rx_data       (rx_data),
      .fw_valid      (fw_valid),
      .fw_ready      (fw_ready_w),
      .fw_data       (fw_data),
      .fr_valid      (fr_valid_w),
      .fr_ready      (fr_ready),
      .fr_data       (fr_data_w),
      .tx_valid      (tx_valid),
      .tx_ready      (tx_ready),
      .tx_data       (tx_data)
   );

   always @(negedge clk) begin
      if (loop && !rst && tx_valid && tx_ready) cap.push_back(tx_data);
   end

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [35:0] act, input logic [35:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int npieces(input logic b);
      return b ? 4 : 2;
   endfunction

   function automatic int slot_of(input logic l, input int k, input int n);
      return l ? k : n - 1 - k;
   endfunction

   function automatic logic [35:0] exp_word(input logic b, input logic l);
      logic [35:0] w = '0;
      int n = npieces(b);
      for (int k = 0; k < n; k++) begin
         if (b) w[slot_of(l, k, n)*9 +: 9]   = pcs[k][8:0];
         else   w[slot_of(l, k, n)*18 +: 18] = pcs[k];
      end
      return w;
   endfunction

   function automatic logic [17:0] exp_piece(input logic b, input logic l,
                                             input logic [35:0] w, input int k);
      int n = npieces(b);
      if (b) return {9'b0, w[slot_of(l, k, n)*9 +: 9]};
      return w[slot_of(l, k, n)*18 +: 18];
   endfunction

   // Called at a negedge; returns at the negedge after acceptance
   task automatic push(input logic [17:0] d);
      rx_valid = 1'b1;
      rx_data  = d;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   // R8: selects are flipped right after reset; the captured ones must rule
   task automatic do_reset(input logic b, input logic l);
      @(negedge clk);
      rst = 1'b1; cfg_byte = b; cfg_lsb = l;
      rx_valid = 1'b0; drv_fr_valid = 1'b0; drv_fw_ready = 1'b0; tx_ready = 1'b0;
      @(negedge clk);
      chk("R9", "fw_valid during reset", 36'(fw_valid), 36'd0);
      chk("R9", "tx_valid during reset", 36'(tx_valid), 36'd0);
      @(negedge clk);
      rst = 1'b0; cfg_byte = ~b; cfg_lsb = ~l;
      chk("R9", "rx_ready after reset", 36'(rx_ready), 36'd1);
      chk("R9", "fr_ready after reset", 36'(fr_ready), 36'd1);
   endtask

   function automatic string pack_req(input logic b, input logic l);
      if (b) return "R3";
      return l ? "R2" : "R1";
   endfunction

   task automatic pack_test(input logic b, input logic l, input int seed);
      int n = npieces(b);
      for (int k = 0; k < 4; k++)
         pcs[k] = 18'((seed * 40503 + k * 9973 + 12345) & 32'h3FFFF) | 18'h20200;
      for (int k = 0; k < n - 1; k++) begin
         push(pcs[k]);
         chk("R4", "fw_valid before last piece", 36'(fw_valid), 36'd0);
      end
      push(pcs[n-1]);
      chk("R4", "fw_valid after last piece", 36'(fw_valid), 36'd1);
      chk(pack_req(b, l), "packed word", fw_data, exp_word(b, l));
      chk("R8", "word uses reset-time selects", fw_data, exp_word(b, l));
      chk("R4", "rx_ready while word waits", 36'(rx_ready), 36'd0);
      @(negedge clk);
      chk("R4", "word held under stall", fw_data, exp_word(b, l));
      drv_fw_ready = 1'b1;
      @(negedge clk);
      drv_fw_ready = 1'b0;
      chk("R4", "fw_valid after drain", 36'(fw_valid), 36'd0);
   endtask

   task automatic unpack_test(input logic b, input logic l, input logic [35:0] w);
      int n = npieces(b);
      string rq = b ? "R6" : "R5";
      logic [35:0] w2 = ~w;
      drv_fr_valid = 1'b1; drv_fr_data = w; tx_ready = 1'b0;
      chk("R7", "fr_ready when empty", 36'(fr_ready), 36'd1);
      @(negedge clk);
      drv_fr_data = w2;
      chk(rq, "tx_valid after pop", 36'(tx_valid), 36'd1);
      chk(rq, "first piece", 36'(tx_data), 36'(exp_piece(b, l, w, 0)));
      chk("R7", "no pop mid word", 36'(fr_ready), 36'd0);
      @(negedge clk);
      chk("R7", "piece held under stall", 36'(tx_data), 36'(exp_piece(b, l, w, 0)));
      tx_ready = 1'b1;
      for (int k = 0; k < n; k++) begin
         chk(rq, "piece order", 36'(tx_data), 36'(exp_piece(b, l, w, k)));
         chk("R7", "fr_ready at piece", 36'(fr_ready), (k == n - 1) ? 36'd1 : 36'd0);
         @(negedge clk);
      end
      drv_fr_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         chk(rq, "back-to-back word piece", 36'(tx_data), 36'(exp_piece(b, l, w2, k)));
         @(negedge clk);
      end
      chk(rq, "tx_valid after drain", 36'(tx_valid), 36'd0);
      tx_ready = 1'b0;
   endtask

   task automatic loop_test(input logic b, input logic l);
      int n = npieces(b);
      do_reset(b, l);
      loop = 1'b1; tx_ready = 1'b1;
      cap.delete(); sent.delete();
      for (int i = 0; i < 5 * n; i++) begin
         logic [17:0] d = 18'((i * 28657 + 777 + (b ? 3 : 0) + (l ? 5 : 0)) & 32'h3FFFF);
         push(d);
         sent.push_back(b ? {9'b0, d[8:0]} : d);
      end
      repeat (12) @(negedge clk);
      chk("R10", "loopback piece count", 36'(cap.size()), 36'(sent.size()));
      for (int i = 0; i < sent.size() && i < cap.size(); i++)
         chk("R10", "loopback piece", 36'(cap[i]), 36'(sent[i]));
      loop = 1'b0; tx_ready = 1'b0;
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      // R1 R2 R3 R5 R6 R8: each size/order pair on both halves
      for (int c = 0; c < 4; c++) begin
         logic b = c[1];
         logic l = c[0];
         do_reset(b, l);
         pack_test(b, l, c + 1);
         pack_test(b, l, c + 11);
         unpack_test(b, l, 36'h9_A5C3_1E7B ^ 36'(c * 36'h1_0203_0405));
      end
      // R9: stray partial word before reset must not leak into the next word
      do_reset(1'b1, 1'b0);
      push(18'h3FFFF);
      do_reset(1'b1, 1'b0);
      pack_test(1'b1, 1'b0, 21);
      do_reset(1'b0, 1'b1);
      push(18'h15555);
      do_reset(1'b0, 1'b1);
      pack_test(1'b0, 1'b1, 22);
      // R9: partly sent word is dropped by reset
      do_reset(1'b1, 1'b1);
      drv_fr_valid = 1'b1; drv_fr_data = 36'hF_FFFF_FFFF;
      @(negedge clk);
      drv_fr_valid = 1'b0; tx_ready = 1'b1;
      @(negedge clk);
      do_reset(1'b1, 1'b1);
      chk("R9", "tx_valid after mid-word reset", 36'(tx_valid), 36'd0);
      unpack_test(1'b1, 1'b1, 36'h1_2345_6789);
      // R10: loopback in all four combinations
      for (int c = 0; c < 4; c++) loop_test(c[1], c[0]);
      report();
   end

endmodule